// File: doc/BRIEF.md
# Signed Decade Result Accumulator

This block holds the running result of a multi-pass integrating conversion as a sign and a six-decade BCD magnitude. Each cycle in which the sequencer enables counting, a single unit is added to or taken from one chosen decade. Carries and borrows propagate across all decades inside that same cycle. The sequencer uses a coarser decade for the main de-integrate pass and a finer one for each residue pass. During the offset pass it raises a direction-invert input, so the same counting action subtracts the offset reading. When the value crosses zero, the sign flips and the magnitude keeps counting away from zero.

When a conversion ends, a latch strobe copies the value into an output register. The copy omits the lowest decades, which are only guard digits. At the same edge, an over-range flag and an under-range flag are computed from the copied value. A two-bit mode input selects one of three behaviours: normal run, hold (strobes are ignored and the last reading stays), or live (the reading outputs show the counter itself).

Top module: `bcd_result_acc`

## Requirements
- R1: While reset is low, the counter is set to magnitude zero with a positive sign. The latched reading, its sign and both range flags are set to zero.
- R2: `clear` high sets the counter to zero with a positive sign at the next edge, even if `cnt_en` is high in the same cycle.
- R3: With `cnt_en` high, one count changes the magnitude by 10^`wsel`. All carries and borrows settle within that clock. A `wsel` value of NDEC or more leaves the counter unchanged.
- R4: The step is negative when `cnt_dn` XOR `zero_pass` is 1 and positive otherwise, so `zero_pass`=1 subtracts what it counts.
- R5: A step that passes through zero gives magnitude = weight − old magnitude and flips the sign. A zero magnitude always carries a positive sign.
- R6: A step that would push the magnitude beyond all nines saturates at all nines and keeps the sign.
- R7: The reading omits the NDROP lowest decades of the magnitude. Digit i occupies bits [4i+3:4i], and the sign is a separate output (1 = negative).
- R8: In run mode (`mode`=00 or 11), the reading, its sign and both flags take the counter's value from before the edge at which `latch` is high. At every other edge they stay unchanged.
- R9: `over_rng` is latched as 1 when the displayed magnitude exceeds OVER_LIM (19999).
- R10: `under_rng` is latched as 1 when the displayed magnitude is below UNDER_LIM (1000).
- R11: In hold mode (`mode`=01), `latch` is ignored. The reading, its sign and both flags keep their values.
- R12: In live mode (`mode`=10), `shown_mag` and `shown_neg` follow the counter directly, while the flags are still latched as in R8.
- R13: Every counter decade always holds a value from 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Zero the counter at the start of a conversion |
| cnt_en | input | 1 | Count one unit this cycle |
| cnt_dn | input | 1 | Count direction, 1 = negative step |
| zero_pass | input | 1 | Invert the direction during the offset pass |
| wsel | input | $clog2(NDEC) | Decade that receives the unit |
| latch | input | 1 | End-of-conversion strobe |
| mode | input | 2 | 00/11 run, 01 hold, 10 live |
| shown_mag | output | 4*(NDEC-NDROP) | BCD reading magnitude |
| shown_neg | output | 1 | Reading sign, 1 = negative |
| over_rng | output | 1 | Latched over-range flag |
| under_rng | output | 1 | Latched under-range flag |

## Verification
The counter is exercised with a long pseudo-random walk. Each step picks a weight, a direction and a direction-invert setting at random, and the live reading is compared after every step against a signed integer model. This distinguishes carry and borrow errors, sign-crossing errors and errors in the invert logic. Directed patterns then load values on both sides of each flag limit (199990, 200000, 9990, 10000, and a negative over-range value) to separate off-by-one faults in the limit comparisons. Further patterns cover stepping through zero, saturation at all nines, and out-of-range decade selects. The run, hold and live modes each receive a strobe, so a reading that updates when it should not, or fails to update when it should, is caught.

// File: rtl/bcd_result_acc.sv
module bcd_result_acc #(
  parameter int NDEC      = 6,
  parameter int NDROP     = 1,
  parameter int OVER_LIM  = 19999,
  parameter int UNDER_LIM = 1000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        cnt_en,
  input  logic                        cnt_dn,
  input  logic                        zero_pass,
  input  logic [$clog2(NDEC)-1:0]     wsel,
  input  logic                        latch,
  input  logic [1:0]                  mode,
  output logic [4*(NDEC-NDROP)-1:0]   shown_mag,
  output logic                        shown_neg,
  output logic                        over_rng,
  output logic                        under_rng
);
  localparam int MW = 4 * NDEC;
  localparam int SW = 4 * (NDEC - NDROP);
  localparam logic [1:0] M_HOLD = 2'b01;
  localparam logic [1:0] M_LIVE = 2'b10;

  function automatic logic [MW:0] bcd_as(input logic [MW-1:0] a, input logic [MW-1:0] b,
                                         input logic sub);
    logic [MW-1:0] r;
    int c, d;
    c = 0;
    r = '0;
    for (int i = 0; i < NDEC; i++) begin
      if (!sub) begin
        d = int'(a[4*i+:4]) + int'(b[4*i+:4]) + c;
        c = (d > 9) ? 1 : 0;
        if (c == 1) d = d - 10;
      end else begin
        d = int'(a[4*i+:4]) - int'(b[4*i+:4]) - c;
        c = (d < 0) ? 1 : 0;
        if (c == 1) d = d + 10;
      end
      r[4*i+:4] = 4'(d);
    end
    return {c[0], r};
  endfunction

  function automatic int bcd_val(input logic [SW-1:0] v);
    int acc;
    acc = 0;
    for (int i = NDEC - NDROP - 1; i >= 0; i--) acc = acc * 10 + int'(v[4*i+:4]);
    return acc;
  endfunction

  logic [MW-1:0] cnt_mag, nxt_mag, wvec;
  logic          cnt_neg, nxt_neg, grow;
  logic [MW:0]   sum, dif, rev;
  logic [SW-1:0] lat_mag, top_mag;
  logic          lat_neg;

  always_comb begin
    wvec = '0;
    for (int i = 0; i < NDEC; i++)
      if (int'(wsel) == i) wvec[4*i] = 1'b1;
  end

  assign grow    = (cnt_dn ^ zero_pass) == cnt_neg;
  assign sum     = bcd_as(cnt_mag, wvec, 1'b0);
  assign dif     = bcd_as(cnt_mag, wvec, 1'b1);
  assign rev     = bcd_as(wvec, cnt_mag, 1'b1);
  assign top_mag = cnt_mag[MW-1:4*NDROP];

  always_comb begin
    nxt_neg = cnt_neg;
    if (grow)
      nxt_mag = sum[MW] ? {NDEC{4'h9}} : sum[MW-1:0];
    else if (dif[MW]) begin
      nxt_mag = rev[MW-1:0];
      nxt_neg = ~cnt_neg;
    end else
      nxt_mag = dif[MW-1:0];
    if (nxt_mag == '0) nxt_neg = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt_mag <= '0;
      cnt_neg <= 1'b0;
    end else if (cnt_en) begin
      cnt_mag <= nxt_mag;
      cnt_neg <= nxt_neg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_mag   <= '0;
      lat_neg   <= 1'b0;
      over_rng  <= 1'b0;
      under_rng <= 1'b0;
    end else if (latch && mode != M_HOLD) begin
      lat_mag   <= top_mag;
      lat_neg   <= cnt_neg;
      over_rng  <= bcd_val(top_mag) > OVER_LIM;
      under_rng <= bcd_val(top_mag) < UNDER_LIM;
    end
  end

  assign shown_mag = (mode == M_LIVE) ? top_mag : lat_mag;
  assign shown_neg = (mode == M_LIVE) ? cnt_neg : lat_neg;

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_mag == '0 && !cnt_neg));
  assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !cnt_en) |=> ($stable(cnt_mag) && $stable(cnt_neg)));
  assert_wsel_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && cnt_en && int'(wsel) >= NDEC) |=> $stable(cnt_mag));
  assert_zero_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_mag == '0) |-> !cnt_neg);
  assert_flip_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dif[MW] |-> !rev[MW]);
  assert_latch_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> ($stable(lat_mag) && $stable(lat_neg) && $stable(over_rng) && $stable(under_rng)));
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_HOLD) |=> ($stable(lat_mag) && $stable(over_rng) && $stable(under_rng)));
  assert_flag_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(over_rng && under_rng));

  for (genvar g = 0; g < NDEC; g++) begin : g_digit_chk
    assert_digit_R13: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_mag[4*g+:4] <= 4'd9);
  end
endmodule

// File: tb/sim_bcd_result_acc.sv
module sim_bcd_result_acc;
  logic clk = 1'b0;
  logic rst_n, clear, cnt_en, cnt_dn, zero_pass, latch;
  logic [2:0]  wsel;
  logic [1:0]  mode;
  logic [19:0] shown_mag;
  logic        shown_neg, over_rng, under_rng;
  int nchk = 0, nfail = 0, ref_v = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  bcd_result_acc u0 (.clk, .rst_n, .clear, .cnt_en, .cnt_dn, .zero_pass, .wsel,
                     .latch, .mode, .shown_mag, .shown_neg, .over_rng, .under_rng);

  function automatic logic [19:0] to_bcd(input int m);
    logic [19:0] r;
    for (int i = 0; i < 5; i++) begin
      r[4*i+:4] = 4'(m % 10);
      m = m / 10;
    end
    return r;
  endfunction

  function automatic int mag_of(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step(input int k, input bit dn, input bit zp);
    int s;
    cnt_en = 1'b1; cnt_dn = dn; zero_pass = zp; wsel = 3'(k);
    @(negedge clk);
    cnt_en = 1'b0;
    s = (dn ^ zp) ? -1 : 1;
    if (k < 6) ref_v = ref_v + s * (10 ** k);
    if (ref_v > 999999) ref_v = 999999;
    if (ref_v < -999999) ref_v = -999999;
  endtask

  task automatic do_clear();
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    ref_v = 0;
  endtask

  task automatic load(input int v);
    int m;
    do_clear();
    m = mag_of(v);
    for (int d = 0; d < 6; d++) begin
      for (int n = 0; n < m % 10; n++) step(d, v < 0, 1'b0);
      m = m / 10;
    end
  endtask

  task automatic strobe(input logic [1:0] md);
    mode = md; latch = 1'b1;
    @(negedge clk);
    latch = 1'b0;
  endtask

  task automatic chk_live(input string tag);
    chk({tag, " magnitude"}, 32'(shown_mag), 32'(to_bcd(mag_of(ref_v) / 10)));
    chk({tag, " sign"}, 32'(shown_neg), 32'(ref_v < 0));
  endtask

  initial begin
    rst_n = 0; clear = 0; cnt_en = 0; cnt_dn = 0; zero_pass = 0; latch = 0;
    wsel = 0; mode = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset reading", 32'(shown_mag), 0);
    chk("R1 reset sign", 32'(shown_neg), 0);
    chk("R1 reset over", 32'(over_rng), 0);
    chk("R1 reset under", 32'(under_rng), 0);

    mode = 2'b10;
    for (int k = 0; k < 6; k++) begin
      step(k, 1'b0, 1'b0);
      chk_live("R3 weight up");
    end
    step(0, 1'b1, 1'b0);
    chk_live("R3 borrow ripple");
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(int'(lfsr[2:0]), lfsr[5], lfsr[9]);
      chk_live("R3 R4 R5 R6 random walk");
    end

    load(30);
    step(2, 1'b1, 1'b0);
    chk("R5 cross zero magnitude", 32'(shown_mag), 32'(to_bcd(7)));
    chk("R5 cross zero sign", 32'(shown_neg), 1);
    load(5);
    for (int n = 0; n < 5; n++) step(0, 1'b1, 1'b0);
    step(1, 1'b1, 1'b0);
    step(1, 1'b0, 1'b0);
    chk("R5 zero is positive", 32'(shown_neg), 0);

    do_clear();
    for (int n = 0; n < 4; n++) step(1, 1'b0, 1'b1);
    chk("R4 offset pass magnitude", 32'(shown_mag), 32'(to_bcd(4)));
    chk("R4 offset pass sign", 32'(shown_neg), 1);
    for (int n = 0; n < 2; n++) step(1, 1'b1, 1'b1);
    chk_live("R4 invert of down");

    load(900000);
    step(5, 1'b0, 1'b0);
    chk("R6 saturate", 32'(shown_mag), 32'(to_bcd(99999)));
    load(-900000);
    step(5, 1'b1, 1'b0);
    chk("R6 saturate negative", 32'(shown_mag), 32'(to_bcd(99999)));
    chk("R6 saturate sign", 32'(shown_neg), 1);

    load(1234);
    step(6, 1'b0, 1'b0);
    step(7, 1'b1, 1'b0);
    chk("R3 wsel out of range", 32'(shown_mag), 32'(to_bcd(123)));
    chk("R7 low decade dropped", 32'(shown_mag), 32'h123);

    cnt_en = 1'b1; wsel = 3'd3; clear = 1'b1;
    @(negedge clk);
    cnt_en = 1'b0; clear = 1'b0; ref_v = 0;
    chk("R2 clear over count", 32'(shown_mag), 0);

    mode = 2'b00;
    load(199990); strobe(2'b00);
    chk("R8 latched reading", 32'(shown_mag), 32'(to_bcd(19999)));
    chk("R9 at limit not over", 32'(over_rng), 0);
    chk("R10 above limit not under", 32'(under_rng), 0);
    load(200000);
    chk("R8 no update without strobe", 32'(shown_mag), 32'(to_bcd(19999)));
    strobe(2'b00);
    chk("R9 over", 32'(over_rng), 1);
    load(9990); strobe(2'b11);
    chk("R10 under", 32'(under_rng), 1);
    chk("R9 cleared", 32'(over_rng), 0);
    load(10000); strobe(2'b00);
    chk("R10 at limit not under", 32'(under_rng), 0);
    load(-250000); strobe(2'b00);
    chk("R9 negative over", 32'(over_rng), 1);
    chk("R8 latched sign", 32'(shown_neg), 1);

    load(5000); strobe(2'b01);
    chk("R11 hold reading", 32'(shown_mag), 32'(to_bcd(25000)));
    chk("R11 hold sign", 32'(shown_neg), 1);
    chk("R11 hold flag", 32'(over_rng), 1);
    mode = 2'b10;
    @(negedge clk);
    chk("R12 live reading", 32'(shown_mag), 32'(to_bcd(500)));
    chk("R12 live sign", 32'(shown_neg), 0);
    chk("R12 flag still latched", 32'(over_rng), 1);
    strobe(2'b10);
    chk("R12 flag latched in live", 32'(under_rng), 1);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule